// File: doc/BRIEF.md
# Cascadable Serial Gauge Command Port

This block is the command receiver of a gauge driver. A host frames a transfer by raising a select line. While the select line is high, the host clocks a 10-bit command in on a serial data line, most significant bit first. The bit that leaves the top of the shift register is presented on a serial output that is always driven. Several such ports can therefore be wired output-to-input in one chain and loaded with a single long frame.

Shifting never disturbs what the rest of the driver sees. Only when the select line falls is the shifted word copied into a holding register. That event also raises a one-cycle update strobe, samples the output-enable request and clears the fault flag that is raised at power-up.

All serial pins are asynchronous to the block's system clock. Each pin is brought in through a two-stage synchroniser. Edges are then found by comparing the synchronised level with its value one cycle earlier. A pin change therefore takes effect on the third system-clock edge after it is applied.

Top module: `gauge_cmd_port`

## Requirements
- R1: During and directly after reset, the command word is 0, the serial output is 0, the update strobe is 0, the output-enable flag is 0 and the fault flag is 1.
- R2: On each rising serial-clock edge seen while select is high, the serial data level is shifted into bit 0 of a 10-bit shift register, and the older bits move up by one place. A complete frame therefore lands most significant bit first. Every pin change takes effect on the third system-clock edge after it is applied.
- R3: Serial-clock edges that arrive while select is low change neither the shift register nor the serial output.
- R4: On each falling serial-clock edge seen while select is high, the serial output takes bit 9 of the shift register. At no other time does it change. The first bit of a frame reappears on the serial output after ten further clock pulses.
- R5: The command word changes only at a falling edge of select, when it takes the whole shift register. The update strobe is high for exactly one system-clock cycle after each such edge.
- R6: When a frame carries more than 10 clock pulses, the last 10 bits received are the ones latched.
- R7: The fault flag is 1 from reset until the first falling edge of select. It then drops to 0 and stays 0.
- R8: At each falling edge of select, the output-enable flag takes the level of the output-enable request pin. At any other time it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock that samples all serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host |
| csIn | input | 1 | Frame select, high while shifting |
| siIn | input | 1 | Serial data in |
| oeIn | input | 1 | Output-enable request, sampled at the end of a frame |
| soOut | output | 1 | Serial data out toward the next device in the chain |
| faultOut | output | 1 | Power-up fault flag |
| cmdWord | output | 10 | Latched command word |
| cmdUpdate | output | 1 | One-cycle strobe when the command word is loaded |
| outEnable | output | 1 | Output-enable flag latched at the end of a frame |

## Verification
The first pattern is a frame whose serial clocks arrive while select is low, followed by a bare select pulse. Its latched word stays zero, which separates gated from ungated shifting, and the same pulse shows the fault clearing. A 10-bit frame with an asymmetric code separates MSB-first from LSB-first loading and shows the word holding still until select falls. A 13-pulse frame tells last-ten retention apart from first-ten retention. A 20-pulse frame carries two words: it proves that the first word comes back out on the serial output in order, one word later. Throughout all of these, a behavioural model of the pin history is compared against every output on every cycle. This model catches off-by-one latency and strobe-width errors.

// File: rtl/gauge_cmd_pkg.sv
package gauge_cmd_pkg;
  localparam int PIN_SCLK  = 0;
  localparam int PIN_CS    = 1;
  localparam int PIN_SI    = 2;
  localparam int PIN_OE    = 3;
  localparam int PIN_COUNT = 4;

  typedef struct packed {
    logic shiftEn;  // rising serial clock inside a frame
    logic soLoad;   // falling serial clock inside a frame
    logic commit;   // falling select
  } ctrlStrobes_t;
endpackage

// File: rtl/gauge_cmd_ctrl.sv
module gauge_cmd_ctrl
  import gauge_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         sysClk,
  input  logic         rstN,
  input  logic         sclkIn,
  input  logic         csIn,
  input  logic         siIn,
  input  logic         oeIn,
  output ctrlStrobes_t strobes,
  output logic         siBit,
  output logic         oeLevel,
  output logic         faultOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinNow;
  logic [PIN_COUNT-1:0] pinPrev;
  logic [PIN_COUNT-1:0] pinRaw;

  assign pinRaw[PIN_SCLK] = sclkIn;
  assign pinRaw[PIN_CS]   = csIn;
  assign pinRaw[PIN_SI]   = siIn;
  assign pinRaw[PIN_OE]   = oeIn;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
      pinPrev <= '0;
    end else begin
      syncStage[0] <= pinRaw;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      pinPrev <= syncStage[LAST];
    end
  end

  assign pinNow = syncStage[LAST];

  logic sclkRise, sclkFall, csFall;
  assign sclkRise = pinNow[PIN_SCLK] & ~pinPrev[PIN_SCLK];
  assign sclkFall = ~pinNow[PIN_SCLK] & pinPrev[PIN_SCLK];
  assign csFall   = ~pinNow[PIN_CS] & pinPrev[PIN_CS];

  always_comb begin
    strobes.shiftEn = sclkRise & pinNow[PIN_CS];
    strobes.soLoad  = sclkFall & pinNow[PIN_CS];
    strobes.commit  = csFall;
  end

  assign siBit   = pinNow[PIN_SI];
  assign oeLevel = pinNow[PIN_OE];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)       faultOut <= 1'b1;
    else if (csFall) faultOut <= 1'b0;
  end

  assert_fault_sticky_R7: assert property (@(posedge sysClk) disable iff (!rstN)
    !faultOut |=> !faultOut);
  assert_strobe_exclusive_R2: assert property (@(posedge sysClk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/gauge_cmd_datapath.sv
module gauge_cmd_datapath
  import gauge_cmd_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              siBit,
  input  logic              oeLevel,
  output logic              soOut,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdUpdate,
  output logic              outEnable
);
  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      soOut     <= 1'b0;
      cmdWord   <= '0;
      cmdUpdate <= 1'b0;
      outEnable <= 1'b0;
    end else begin
      cmdUpdate <= strobes.commit;
      if (strobes.shiftEn) shiftReg <= {shiftReg[TOP-1:0], siBit};
      if (strobes.soLoad)  soOut    <= shiftReg[TOP];
      if (strobes.commit) begin
        cmdWord   <= shiftReg;
        outEnable <= oeLevel;
      end
    end
  end

  assert_hold_stable_R5: assert property (@(posedge sysClk) disable iff (!rstN)
    !strobes.commit |=> $stable(cmdWord));
  assert_update_single_R5: assert property (@(posedge sysClk) disable iff (!rstN)
    cmdUpdate |=> !cmdUpdate);
  assert_so_quiet_R4: assert property (@(posedge sysClk) disable iff (!rstN)
    !strobes.soLoad |=> $stable(soOut));
  assert_oe_hold_R8: assert property (@(posedge sysClk) disable iff (!rstN)
    !strobes.commit |=> $stable(outEnable));
endmodule

// File: rtl/gauge_cmd_port.sv
module gauge_cmd_port
  import gauge_cmd_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csIn,
  input  logic              siIn,
  input  logic              oeIn,
  output logic              soOut,
  output logic              faultOut,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdUpdate,
  output logic              outEnable
);
  ctrlStrobes_t strobes;
  logic siBit, oeLevel;

  gauge_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk(sysClk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .siIn(siIn),
    .oeIn(oeIn), .strobes(strobes), .siBit(siBit), .oeLevel(oeLevel),
    .faultOut(faultOut)
  );

  gauge_cmd_datapath #(.WORD_W(WORD_W)) u_datapath (
    .sysClk(sysClk), .rstN(rstN), .strobes(strobes), .siBit(siBit),
    .oeLevel(oeLevel), .soOut(soOut), .cmdWord(cmdWord),
    .cmdUpdate(cmdUpdate), .outEnable(outEnable)
  );
endmodule

// File: tb/gauge_cmd_port_bench.sv
module gauge_cmd_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int HALF_SCLK  = 4;

  logic sysClk = 0, rstN = 0;
  logic sclkIn = 0, csIn = 0, siIn = 0, oeIn = 0;
  logic soOut, faultOut, cmdUpdate, outEnable;
  logic [9:0] cmdWord;

  int checks = 0, failures = 0, cycles = 0, updPulses = 0;
  bit done = 0;

  gauge_cmd_port u_gauge_cmd_port (
    .sysClk(sysClk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .siIn(siIn),
    .oeIn(oeIn), .soOut(soOut), .faultOut(faultOut), .cmdWord(cmdWord),
    .cmdUpdate(cmdUpdate), .outEnable(outEnable)
  );

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: history of applied pin levels, newest first
  bit [3:0] hist [$];
  bit [9:0] mShift, mHold;
  bit mSo, mUpd, mFault, mOe;

  initial for (int i = 0; i <= SYNC; i++) hist.push_back(4'b0);

  always @(posedge sysClk) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC; i++) hist[i] = 4'b0;
      mShift = 0; mHold = 0; mSo = 0; mUpd = 0; mFault = 1; mOe = 0;
    end else begin
      bit [3:0] now, prv;
      bit [9:0] oldShift;
      now = hist[SYNC-1];
      prv = hist[SYNC];
      oldShift = mShift;
      mUpd = 0;
      if (prv[1] && !now[1]) begin
        mHold = oldShift; mUpd = 1; mOe = now[3]; mFault = 0;
      end
      if (now[0] && !prv[0] && now[1]) mShift = {oldShift[8:0], now[2]};
      if (!now[0] && prv[0] && now[1]) mSo = oldShift[9];
      void'(hist.pop_back());
      hist.push_front({oeIn, siIn, csIn, sclkIn});
    end
  end

  always @(negedge sysClk) begin
    if (rstN && !done) begin
      chk("R4 soOut vs model", soOut, mSo);
      chk("R5 cmdWord vs model", cmdWord, mHold);
      chk("R5 cmdUpdate vs model", cmdUpdate, mUpd);
      chk("R7 faultOut vs model", faultOut, mFault);
      chk("R8 outEnable vs model", outEnable, mOe);
      if (cmdUpdate) updPulses++;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic frame(input logic [31:0] val, input int nbits, input logic oe,
                       input logic selHigh, output logic [9:0] soCap);
    soCap = 0;
    csIn = selHigh;
    waitCyc(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      siIn = val[i];
      sclkIn = 0;
      waitCyc(HALF_SCLK);
      soCap = {soCap[8:0], soOut};
      sclkIn = 1;
      waitCyc(HALF_SCLK);
    end
    sclkIn = 0;
    waitCyc(HALF_SCLK);
    oeIn = oe;
    waitCyc(2);
    csIn = 0;
    waitCyc(8);
  endtask

  initial begin
    logic [9:0] cap;
    waitCyc(4);
    // R1: reset state
    chk("R1 cmdWord", cmdWord, 0);
    chk("R1 soOut", soOut, 0);
    chk("R1 cmdUpdate", cmdUpdate, 0);
    chk("R1 outEnable", outEnable, 0);
    chk("R1 faultOut", faultOut, 1);
    rstN = 1;
    waitCyc(3);
    chk("R1 faultOut after release", faultOut, 1);

    // R3: clocks with select low are ignored
    frame(32'h3FF, 10, 1'b0, 1'b0, cap);
    chk("R3 soOut untouched", soOut, 0);
    chk("R7 fault still set without pulse", faultOut, 1);
    csIn = 1; waitCyc(6); csIn = 0; waitCyc(6);
    chk("R3 word zero after gated clocks", cmdWord, 0);
    chk("R7 fault cleared by select pulse", faultOut, 0);
    chk("R8 enable low", outEnable, 0);

    // R2/R5: MSB-first load, word held until select falls
    csIn = 1; waitCyc(4);
    for (int i = 9; i >= 0; i--) begin
      siIn = 1'(10'h2A5 >> i);
      sclkIn = 0; waitCyc(HALF_SCLK);
      sclkIn = 1; waitCyc(HALF_SCLK);
    end
    sclkIn = 0; oeIn = 1; waitCyc(8);
    chk("R5 word unchanged before select falls", cmdWord, 0);
    csIn = 0;
    waitCyc(2);
    chk("R2 latency two edges no load yet", cmdWord, 0);
    waitCyc(1);
    chk("R2 MSB-first word", cmdWord, 10'h2A5);
    chk("R5 update strobe", cmdUpdate, 1);
    chk("R8 enable taken high", outEnable, 1);
    waitCyc(1);
    chk("R5 strobe one cycle", cmdUpdate, 0);
    waitCyc(5);

    // R6: 13 pulses, last ten kept
    frame(32'h15A3, 13, 1'b0, 1'b1, cap);
    chk("R6 last ten bits", cmdWord, 10'h1A3);
    chk("R8 enable taken low", outEnable, 0);

    // R4: two words, first emerges on SO
    frame({12'h0, 10'h3C1, 10'h05E}, 20, 1'b1, 1'b1, cap);
    chk("R4 cascaded SO stream", cap, 10'h3C1);
    chk("R6 second word latched", cmdWord, 10'h05E);
    chk("R7 fault stays clear", faultOut, 0);
    chk("R5 update pulse count", updPulses, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge sysClk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule